// File: doc/BRIEF.md
# Banked Address Pointer Pair with Per-Pointer Count Direction

This block holds two 16-bit address pointers and a small control register for an 8-bit microcontroller core. At any moment one pointer is the active one. Its value is driven on `act_ptr` and is used as the address for every indirect external data access. Loading one pointer with a source address and the other with a destination address lets a copy loop switch between them cheaply, without reloading either one.

Software loads each pointer one byte at a time through a register write port. Pointer 0 sits at the classic single-pointer location, 0x82 for the low byte and 0x83 for the high byte. Pointer 1 takes the two locations just above it, 0x84 low and 0x85 high. The control register sits at 0x86. In it, bit 0 picks the active pointer, bit 6 sets the count direction of pointer 0 and bit 7 sets the count direction of pointer 1. An advance command moves only the active pointer one step, up or down according to that pointer's direction bit. A separate control-increment command adds one to the control register. Bit 1 of that register is hard-wired to zero, so the carry from bit 0 goes nowhere and the command simply toggles the active-pointer choice.

Top module: `dptr_bank`

## Requirements
- R1: After reset, both pointers and the control register read 0x00, and `act_ptr` is 0x0000, so pointer 0 is active and counts up.
- R2: A write to 0x82 loads the low byte of pointer 0. A write to 0x83 loads its high byte. Addresses 0x84 and 0x85 do the same for pointer 1. Reads at these addresses return the stored bytes one cycle after the write.
- R3: The control register at 0x86 stores bit 0 (active choice: 0 = pointer 0, 1 = pointer 1), bit 6 (pointer 0 direction) and bit 7 (pointer 1 direction). Bits 5 to 1 always read 0, whatever value was written.
- R4: `act_ptr` equals pointer 1 when control bit 0 is 1, and pointer 0 otherwise.
- R5: An advance with the active pointer's direction bit at 0 adds 1, and with the bit at 1 subtracts 1. Both wrap modulo 2^16: 0xFFFF steps up to 0x0000, and 0x0000 steps down to 0xFFFF.
- R6: An advance leaves the inactive pointer unchanged.
- R7: A control-increment toggles bit 0 and leaves bits 7 and 6 unchanged.
- R8: If a byte write targets the active pointer in the same cycle as an advance, the write wins. The written byte takes the new data, the other byte keeps its old value, and no step is applied.
- R9: If a control register write and a control-increment occur in the same cycle, the written value is stored and no toggle is applied.
- R10: An advance acts on the pointer that was active before the clock edge, even if the same cycle writes a new active choice.
- R11: Reads at any other address return 0x00, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| adv_ptr | input | 1 | Step the active pointer one position |
| ctl_inc | input | 1 | Add one to the control register |
| rd_addr | input | 8 | Register readback address |
| rd_data | output | 8 | Readback byte (combinational from stored state) |
| act_ptr | output | 16 | Active pointer value |

## Verification
Two pairs of functions can fall in the same cycle. A byte load can land on the pointer that an advance is stepping, and a control write can coincide with either a control-increment or an advance. The bench drives these pairings deliberately. For the pointer case, it writes the active pointer's low byte while advancing, and it also writes the inactive pointer while advancing. For the control case, it writes a new active choice in the same cycle as an advance. Its behavioural model applies the write-wins rule and the old-choice rule independently of the RTL, and both readback and `act_ptr` are compared against the model after every edge, including a long stretch of random overlapping commands.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    // Bit positions inside the control byte. Software decodes these
    // positions, so they are fixed.
    localparam int PICK_BIT  = 0;
    localparam int DOWN0_BIT = 6;
    localparam int DOWN1_BIT = 7;
    localparam int NUM_PTRS  = 2;

    typedef struct packed {
        logic down1;
        logic down0;
        logic pick;
    } ctl_t;
endpackage

// File: rtl/dptr_ctl.sv
module dptr_ctl
    import dptr_pkg::*;
#(
    parameter int              AW       = 8,
    parameter int              DW       = 8,
    parameter logic [AW-1:0]   CTL_ADDR = 8'h86
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  ctl_t          wr_fields,
    input  logic          inc,
    output ctl_t          ctl_q,
    output logic [DW-1:0] ctl_byte
);
    ctl_t ctl_d;
    logic wr_hit;

    assign wr_hit = wr_en && (wr_addr == CTL_ADDR);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            ctl_d = wr_fields;
        end else if (inc) begin
            // bit 1 is tied to zero, so the carry out of bit 0 is lost
            ctl_d.pick = ~ctl_q.pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        ctl_byte            = '0;
        ctl_byte[PICK_BIT]  = ctl_q.pick;
        ctl_byte[DOWN0_BIT] = ctl_q.down0;
        ctl_byte[DOWN1_BIT] = ctl_q.down1;
    end

    // R7
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_hit) |=> (ctl_q.pick != $past(ctl_q.pick))
                             && $stable(ctl_q.down0) && $stable(ctl_q.down1));

    // R9
    ctl_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (ctl_q == $past(wr_fields)));
endmodule

// File: rtl/dptr_slot.sv
module dptr_slot #(
    parameter int            AW      = 8,
    parameter int            DW      = 8,
    parameter logic [AW-1:0] LO_ADDR = 8'h82
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            adv,
    input  logic            down,
    output logic [2*DW-1:0] ptr_q
);
    localparam int            PW      = 2 * DW;
    localparam logic [AW-1:0] HI_ADDR = LO_ADDR + AW'(1);

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } slot_t;

    slot_t         slot_d, slot_q;
    logic          hit_lo, hit_hi, wr_hit;
    logic [PW-1:0] cur;

    assign hit_lo = wr_en && (wr_addr == LO_ADDR);
    assign hit_hi = wr_en && (wr_addr == HI_ADDR);
    assign wr_hit = hit_lo || hit_hi;
    assign cur    = slot_q;

    always_comb begin
        slot_d = slot_q;
        if (hit_lo) begin
            slot_d.lo = wr_data;
        end else if (hit_hi) begin
            slot_d.hi = wr_data;
        end else if (adv) begin
            slot_d = down ? (cur - PW'(1)) : (cur + PW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign ptr_q = slot_q;

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_hit && !down) |=> (ptr_q == PW'($past(ptr_q) + PW'(1))));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_hit && down) |=> (ptr_q == PW'($past(ptr_q) - PW'(1))));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_hit) |=> $stable(ptr_q));

    // R8
    lo_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> (ptr_q[DW-1:0] == $past(wr_data))
                   && (ptr_q[PW-1:DW] == $past(ptr_q[PW-1:DW])));
endmodule

// File: rtl/dptr_rdmux.sv
module dptr_rdmux #(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter int            NP       = 2,
    parameter logic [AW-1:0] P0_ADDR  = 8'h82,
    parameter logic [AW-1:0] CTL_ADDR = 8'h86
) (
    input  logic [AW-1:0]           rd_addr,
    input  logic [NP-1:0][2*DW-1:0] ptrs,
    input  logic [DW-1:0]           ctl_byte,
    output logic [DW-1:0]           rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NP; i++) begin
            if (rd_addr == P0_ADDR + AW'(2 * i))
                rd_data = ptrs[i][DW-1:0];
            if (rd_addr == P0_ADDR + AW'(2 * i + 1))
                rd_data = ptrs[i][2*DW-1:DW];
        end
        if (rd_addr == CTL_ADDR)
            rd_data = ctl_byte;
    end
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
    import dptr_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] P0_ADDR  = 8'h82,
    parameter logic [AW-1:0] CTL_ADDR = 8'h86
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            adv_ptr,
    input  logic            ctl_inc,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic [2*DW-1:0] act_ptr
);
    localparam int PW = 2 * DW;

    ctl_t                      ctl_q;
    ctl_t                      wr_fields;
    logic [DW-1:0]             ctl_byte;
    logic [NUM_PTRS-1:0][PW-1:0] ptrs;

    always_comb begin
        wr_fields.pick  = wr_data[PICK_BIT];
        wr_fields.down0 = wr_data[DOWN0_BIT];
        wr_fields.down1 = wr_data[DOWN1_BIT];
    end

    dptr_ctl #(.AW(AW), .DW(DW), .CTL_ADDR(CTL_ADDR)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_fields (wr_fields),
        .inc       (ctl_inc),
        .ctl_q     (ctl_q),
        .ctl_byte  (ctl_byte)
    );

    for (genvar gi = 0; gi < NUM_PTRS; gi++) begin : g_slot
        logic slot_adv;
        logic slot_down;
        assign slot_adv = adv_ptr && (ctl_q.pick == 1'(gi));
        if (gi == 0) begin : g_dir0
            assign slot_down = ctl_q.down0;
        end else begin : g_dir1
            assign slot_down = ctl_q.down1;
        end
        dptr_slot #(.AW(AW), .DW(DW), .LO_ADDR(P0_ADDR + AW'(2 * gi))) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .adv     (slot_adv),
            .down    (slot_down),
            .ptr_q   (ptrs[gi])
        );
    end

    dptr_rdmux #(.AW(AW), .DW(DW), .NP(NUM_PTRS),
                 .P0_ADDR(P0_ADDR), .CTL_ADDR(CTL_ADDR)) u_rd (
        .rd_addr  (rd_addr),
        .ptrs     (ptrs),
        .ctl_byte (ctl_byte),
        .rd_data  (rd_data)
    );

    assign act_ptr = ptrs[ctl_q.pick];

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == CTL_ADDR) |-> (rd_data[5:1] == '0));

    // R10
    old_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ptr && !wr_en && !ctl_q.pick) |=> $stable(ptrs[1]));
endmodule

// File: tb/sim_dptr_bank.sv
`timescale 1ns/1ps
module sim_dptr_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       adv_ptr = 1'b0;
    logic       ctl_inc = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [15:0] act_ptr;

    int total = 0;
    int bad = 0;

    // behavioural model state
    int unsigned m_p[2];
    bit m_pick, m_dn0, m_dn1;

    always #2 clk = ~clk;

    dptr_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .adv_ptr(adv_ptr), .ctl_inc(ctl_inc),
        .rd_addr(rd_addr), .rd_data(rd_data), .act_ptr(act_ptr)
    );

    function automatic int unsigned exp_rd(input logic [7:0] a);
        case (a)
            8'h82: return m_p[0] & 8'hFF;
            8'h83: return (m_p[0] >> 8) & 8'hFF;
            8'h84: return m_p[1] & 8'hFF;
            8'h85: return (m_p[1] >> 8) & 8'hFF;
            8'h86: return (int'(m_dn1) << 7) | (int'(m_dn0) << 6) | int'(m_pick);
            default: return 0;
        endcase
    endfunction

    task automatic model_edge(input bit we, input logic [7:0] wa, input logic [7:0] wd,
                              input bit av, input bit ci);
        int s = m_pick ? 1 : 0;
        bit own_wr = we && (wa == 8'(8'h82 + 2*s) || wa == 8'(8'h83 + 2*s));
        if (av && !own_wr) begin
            bit dn = s ? m_dn1 : m_dn0;
            m_p[s] = dn ? (m_p[s] + 65535) % 65536 : (m_p[s] + 1) % 65536;
        end
        if (we) begin
            case (wa)
                8'h82: m_p[0] = (m_p[0] & 16'hFF00) | wd;
                8'h83: m_p[0] = (m_p[0] & 16'h00FF) | (int'(wd) << 8);
                8'h84: m_p[1] = (m_p[1] & 16'hFF00) | wd;
                8'h85: m_p[1] = (m_p[1] & 16'h00FF) | (int'(wd) << 8);
                default: ;
            endcase
        end
        if (we && wa == 8'h86) begin
            m_pick = wd[0]; m_dn0 = wd[6]; m_dn1 = wd[7];
        end else if (ci) begin
            m_pick = !m_pick;
        end
    endtask

    task automatic compare(input string tag, input logic [7:0] ra);
        int unsigned ea = m_pick ? m_p[1] : m_p[0];
        int unsigned er = exp_rd(ra);
        total++;
        if (act_ptr !== 16'(ea)) begin
            bad++;
            $display("FAIL %s act_ptr actual=%h expected=%h", tag, act_ptr, 16'(ea));
        end
        total++;
        if (rd_data !== 8'(er)) begin
            bad++;
            $display("FAIL %s rd_data[%h] actual=%h expected=%h", tag, ra, rd_data, 8'(er));
        end
    endtask

    task automatic step(input bit we, input logic [7:0] wa, input logic [7:0] wd,
                        input bit av, input bit ci, input logic [7:0] ra, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; adv_ptr = av; ctl_inc = ci; rd_addr = ra;
        @(posedge clk);
        model_edge(we, wa, wd, av, ci);
        #1;
        compare(tag, ra);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        step(1, a, d, 0, 0, a, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(0, 8'h00, 8'h00, 0, 0, a, tag);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_p[0] = 0; m_p[1] = 0; m_pick = 0; m_dn0 = 0; m_dn1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 8'h82; a <= 8'h86; a++) rd(8'(a), "R1");
        // R2 byte loads
        wr(8'h82, 8'h34, "R2"); wr(8'h83, 8'h12, "R2");
        wr(8'h84, 8'hCD, "R2"); wr(8'h85, 8'hAB, "R2");
        rd(8'h82, "R2"); rd(8'h85, "R2");
        // R4 active choice
        wr(8'h86, 8'h01, "R4"); rd(8'h84, "R4");
        wr(8'h86, 8'h00, "R4");
        // R3 reserved bits
        wr(8'h86, 8'hFF, "R3"); rd(8'h86, "R3");
        wr(8'h86, 8'h00, "R3");
        // R5 count up, wrap up
        step(0, 0, 0, 1, 0, 8'h82, "R5"); step(0, 0, 0, 1, 0, 8'h82, "R5");
        wr(8'h82, 8'hFF, "R5"); wr(8'h83, 8'hFF, "R5");
        step(0, 0, 0, 1, 0, 8'h83, "R5");
        // R5 count down, wrap down
        wr(8'h86, 8'h40, "R5");
        step(0, 0, 0, 1, 0, 8'h82, "R5"); step(0, 0, 0, 1, 0, 8'h83, "R5");
        // R6 inactive untouched
        step(0, 0, 0, 1, 0, 8'h84, "R6"); rd(8'h85, "R6");
        wr(8'h86, 8'h81, "R6");
        step(0, 0, 0, 1, 0, 8'h82, "R6"); rd(8'h84, "R6");
        // R7 control increment
        step(0, 0, 0, 0, 1, 8'h86, "R7"); step(0, 0, 0, 0, 1, 8'h86, "R7");
        // R8 write beats advance on active pointer; inactive write with advance
        step(1, 8'h84, 8'h55, 1, 0, 8'h84, "R8"); rd(8'h85, "R8");
        step(1, 8'h83, 8'h77, 1, 0, 8'h83, "R8"); rd(8'h84, "R8");
        // R9 control write beats increment
        step(1, 8'h86, 8'h00, 0, 1, 8'h86, "R9");
        step(1, 8'h86, 8'hC0, 0, 1, 8'h86, "R9");
        wr(8'h86, 8'h00, "R9");
        // R10 advance uses the old choice
        step(1, 8'h86, 8'h01, 1, 0, 8'h82, "R10"); rd(8'h84, "R10");
        step(1, 8'h86, 8'h80, 1, 0, 8'h84, "R10"); rd(8'h82, "R10");
        // R11 unmapped addresses
        wr(8'h90, 8'hFF, "R11"); rd(8'h90, "R11"); rd(8'h81, "R11");
        wr(8'h87, 8'h5A, "R11"); rd(8'h87, "R11"); rd(8'h86, "R11");
        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            step(1'($urandom_range(0, 1)), 8'($urandom_range(8'h81, 8'h87)),
                 8'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 8'($urandom_range(8'h81, 8'h87)), "R5");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule